// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block selects one of several DMA channels whose requests are pending and runs its byte transfers. A request comes either from the channel's hardware request line or from a software request bit. It is honoured only while the channel's mask bit is clear and the controller is enabled. For the selected channel the block drives the memory address, the transfer direction and a one-hot acknowledge, one byte per clock. It then moves the current address up or down and decrements the current count.

Each channel has a base and current address and a base and current count. A configuration write to an address or count loads the base and current copies together. Each channel also has a mode byte that sets the transfer type, the address direction, autoinitialize and the operating mode (demand, single or block). A run ends at terminal count or when the external end-of-process input is asserted. At the end of a run the channel either reloads its current registers from the base registers (autoinitialize) or masks itself. Terminal count is also recorded in a sticky status flag.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset no transfer is in progress, `dack` is zero, every mask bit is set and every terminal-count flag is clear.
- R2: A channel can be granted only when its request (`dreq` or its software request bit) is high, its mask bit is clear and `ctl_disable` is low. A grant made in an idle cycle puts that channel's first transfer in the next cycle.
- R3: During each transfer cycle `xfer_valid` is high and `dack` is one-hot for the granted channel. `xfer_type` equals mode bits 3:2 (00 verify, 01 write to memory, 10 read from memory).
- R4: `mem_addr` shows the channel's current address. The address then moves by one, downwards when mode bit 5 is set and upwards otherwise, and the count drops by one.
- R5: Terminal count is reached on a transfer made while the current count is zero (the count then wraps to all ones), so a programmed count of N moves N+1 bytes. `tc_out` is high in that cycle.
- R6: When a run ends by terminal count or by `eop_in`, a channel with mode bit 4 clear sets its own mask bit. A channel with mode bit 4 set reloads its current address and count from the base registers and leaves its mask alone. Mask bits are otherwise changed only by `mask_wr`.
- R7: Terminal count sets the channel's bit in `status_tc`. The bit stays set until `status_ack`. `status_req` shows `dreq` OR the software request bits.
- R8: Single mode (mode bits 7:6 = 01) moves one byte per grant, and the block returns to idle for at least one cycle between grants.
- R9: Block mode (mode bits 7:6 = 10) moves bytes on consecutive cycles until terminal count or `eop_in`, whatever `dreq` does.
- R10: Demand mode (mode bits 7:6 = 00) keeps transferring on the next cycle only while the channel's request was high during the current transfer cycle.
- R11: With `ctl_rotate` low, channel 0 has the highest priority and the last channel the lowest. With `ctl_rotate` high, the most recently granted channel has the lowest priority and the search starts from the one above it.
- R12: A software request bit set through `sreq_wr` requests service like `dreq`. It is cleared at that channel's terminal count.
- R13: `eop_in` high during a transfer cycle ends the run after that byte and does not set the terminal-count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | NCH | Hardware request per channel |
| eop_in | input | 1 | External end-of-process, ends the current run |
| ctl_disable | input | 1 | Blocks all new grants |
| ctl_rotate | input | 1 | Selects rotating priority instead of fixed priority |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel selected by the configuration write |
| cfg_sel | input | 2 | 0 address, 1 count, 2 mode byte |
| cfg_data | input | LW | Configuration value; the mode byte is taken from bits 7:0 |
| mask_wr | input | 1 | Writes all mask bits |
| mask_data | input | NCH | New mask value (1 = masked) |
| sreq_wr | input | 1 | Software request bit write strobe |
| sreq_ch | input | CHW | Channel of the software request write |
| sreq_set | input | 1 | New value of the software request bit |
| status_ack | input | 1 | Clears all terminal-count flags |
| xfer_valid | output | 1 | A byte transfer takes place this cycle |
| dack | output | NCH | One-hot acknowledge of the channel being served |
| mem_addr | output | AW | Memory address of the current byte |
| xfer_type | output | 2 | Transfer type of the current byte |
| tc_out | output | 1 | This byte is the terminal-count byte |
| mask_state | output | NCH | Current mask bits |
| status_tc | output | NCH | Sticky terminal-count flags |
| status_req | output | NCH | Pending request per channel |

## Verification
Each operating mode is driven with a request shape chosen to expose it. In single mode the request is held high, so a missing idle gap shows up. In block mode the request is a one-cycle pulse, so a run that wrongly follows the request stops early. In demand mode the request is held for three cycles and then dropped, so the run must stop after exactly three bytes. An end-of-process pulse in the middle of a long block run is used to separate ending by `eop_in` from ending by terminal count. Two channels requesting together are run once under each priority scheme; the order of the second grant tells fixed priority from rotating priority. Disabled and masked channels are held requesting, and the bench confirms that no acknowledge appears.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} seq_state_e;

    // mode byte is stored from bit 2 upward; positions inside the stored field
    localparam int MB_TYPE = 0;
    localparam int MB_AUTO = 2;
    localparam int MB_DEC  = 3;
    localparam int MB_OP   = 4;

    localparam logic [1:0] OPM_DEMAND = 2'b00;
    localparam logic [1:0] OPM_SINGLE = 2'b01;
    localparam logic [1:0] OPM_BLOCK  = 2'b10;

    localparam logic [1:0] CFG_ADDR = 2'd0;
    localparam logic [1:0] CFG_CNT  = 2'd1;
    localparam logic [1:0] CFG_MODE = 2'd2;
endpackage

// File: rtl/dma_addr_step.sv
`timescale 1ns/1ps
module dma_addr_step #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cnt,
    input  logic          dec,
    output logic [AW-1:0] nxt_addr,
    output logic [CW-1:0] nxt_cnt,
    output logic          at_tc
);
    always_comb begin
        nxt_addr = dec ? (addr - 1'b1) : (addr + 1'b1);
        nxt_cnt  = cnt - 1'b1;
        at_tc    = (cnt == '0);
    end
endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    input  logic           rotate,
    input  logic [CHW-1:0] last,
    output logic           vld,
    output logic [CHW-1:0] idx
);
    // scan from lowest to highest priority so the highest one overwrites
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            int cand;
            cand = rotate ? ((int'(last) + 1 + i) % NCH) : i;
            if (req[cand]) begin
                vld = 1'b1;
                idx = CHW'(cand);
            end
        end
    end
endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    parameter  int CW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int LW  = (AW > CW) ? AW : CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] dreq,
    input  logic           eop_in,
    input  logic           ctl_disable,
    input  logic           ctl_rotate,
    input  logic           cfg_wr,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [LW-1:0]  cfg_data,
    input  logic           mask_wr,
    input  logic [NCH-1:0] mask_data,
    input  logic           sreq_wr,
    input  logic [CHW-1:0] sreq_ch,
    input  logic           sreq_set,
    input  logic           status_ack,
    output logic           xfer_valid,
    output logic [NCH-1:0] dack,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     xfer_type,
    output logic           tc_out,
    output logic [NCH-1:0] mask_state,
    output logic [NCH-1:0] status_tc,
    output logic [NCH-1:0] status_req
);
    typedef struct packed {
        seq_state_e                state;
        logic [CHW-1:0]            chan;
        logic [CHW-1:0]            last;
        logic [NCH-1:0]            mask;
        logic [NCH-1:0]            sreq;
        logic [NCH-1:0]            tcf;
        logic [NCH-1:0][AW-1:0]    base_addr;
        logic [NCH-1:0][AW-1:0]    cur_addr;
        logic [NCH-1:0][CW-1:0]    base_cnt;
        logic [NCH-1:0][CW-1:0]    cur_cnt;
        logic [NCH-1:0][5:0]       mode;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [AW-1:0]  step_addr [NCH];
    logic [CW-1:0]  step_cnt  [NCH];
    logic [NCH-1:0] step_tc;
    logic [NCH-1:0] eligible;
    logic           pick_vld;
    logic [CHW-1:0] pick_idx;
    logic           cur_tc;
    logic           stop;
    logic [1:0]     opm;

    for (genvar g = 0; g < NCH; g++) begin : g_step
        dma_addr_step #(.AW(AW), .CW(CW)) u_step (
            .addr     (q.cur_addr[g]),
            .cnt      (q.cur_cnt[g]),
            .dec      (q.mode[g][MB_DEC]),
            .nxt_addr (step_addr[g]),
            .nxt_cnt  (step_cnt[g]),
            .at_tc    (step_tc[g])
        );
    end

    assign eligible = (dreq | q.sreq) & ~q.mask;

    dma_prio_pick #(.NCH(NCH)) u_pick (
        .req    (eligible),
        .rotate (ctl_rotate),
        .last   (q.last),
        .vld    (pick_vld),
        .idx    (pick_idx)
    );

    always_comb begin
        d      = q;
        cur_tc = step_tc[q.chan];
        opm    = q.mode[q.chan][MB_OP +: 2];
        stop   = 1'b0;

        if (status_ack) d.tcf = '0;
        if (mask_wr)    d.mask = mask_data;
        if (sreq_wr)    d.sreq[sreq_ch] = sreq_set;

        case (q.state)
            ST_IDLE: begin
                if (!ctl_disable && pick_vld) begin
                    d.state = ST_XFER;
                    d.chan  = pick_idx;
                    d.last  = pick_idx;
                end
            end
            ST_XFER: begin
                d.cur_addr[q.chan] = step_addr[q.chan];
                d.cur_cnt[q.chan]  = step_cnt[q.chan];
                stop = cur_tc | eop_in;
                if (stop) begin
                    if (q.mode[q.chan][MB_AUTO]) begin
                        d.cur_addr[q.chan] = q.base_addr[q.chan];
                        d.cur_cnt[q.chan]  = q.base_cnt[q.chan];
                    end else begin
                        d.mask[q.chan] = 1'b1;
                    end
                    if (cur_tc) begin
                        d.tcf[q.chan]  = 1'b1;
                        d.sreq[q.chan] = 1'b0;
                    end
                    d.state = ST_IDLE;
                end else if (opm == OPM_SINGLE) begin
                    d.state = ST_IDLE;
                end else if (opm == OPM_DEMAND && !(dreq[q.chan] | q.sreq[q.chan])) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (cfg_wr) begin
            case (cfg_sel)
                CFG_ADDR: begin
                    d.base_addr[cfg_ch] = cfg_data[AW-1:0];
                    d.cur_addr[cfg_ch]  = cfg_data[AW-1:0];
                end
                CFG_CNT: begin
                    d.base_cnt[cfg_ch] = cfg_data[CW-1:0];
                    d.cur_cnt[cfg_ch]  = cfg_data[CW-1:0];
                end
                CFG_MODE: d.mode[cfg_ch] = cfg_data[7:2];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.mask  <= '1;
            q.last  <= CHW'(NCH - 1);
        end else begin
            q <= d;
        end
    end

    assign xfer_valid = (q.state == ST_XFER);
    assign dack       = xfer_valid ? (NCH'(1) << q.chan) : '0;
    assign mem_addr   = q.cur_addr[q.chan];
    assign xfer_type  = q.mode[q.chan][MB_TYPE +: 2];
    assign tc_out     = xfer_valid & cur_tc;
    assign mask_state = q.mask;
    assign status_tc  = q.tcf;
    assign status_req = dreq | q.sreq;
endmodule

// File: rtl/dma_seq_chk.sv
`timescale 1ns/1ps
module dma_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           xfer_valid,
    input logic [NCH-1:0] dack,
    input logic           tc_out,
    input logic [NCH-1:0] mask_state,
    input logic           mask_wr,
    input logic [NCH-1:0] status_tc,
    input logic           ctl_disable
);
    // R3
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R5
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        tc_out |-> xfer_valid);

    // R2
    disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_disable && !xfer_valid) |=> !xfer_valid);

    // R2
    no_masked_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_valid |=> ((dack & $past(mask_state)) == '0));

    // R7
    tc_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tc_out |=> ((status_tc & $past(dack)) != '0));

    // R6
    mask_rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> (($past(mask_state) & ~mask_state) == '0));
endmodule

bind dma_xfer_seq dma_seq_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xfer_valid  (xfer_valid),
    .dack        (dack),
    .tc_out      (tc_out),
    .mask_state  (mask_state),
    .mask_wr     (mask_wr),
    .status_tc   (status_tc),
    .ctl_disable (ctl_disable)
);

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  dreq = '0;
    logic        eop_in = 1'b0, ctl_disable = 1'b0, ctl_rotate = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_ch = '0, cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        mask_wr = 1'b0;
    logic [3:0]  mask_data = '0;
    logic        sreq_wr = 1'b0;
    logic [1:0]  sreq_ch = '0;
    logic        sreq_set = 1'b0, status_ack = 1'b0;
    logic        xfer_valid, tc_out;
    logic [3:0]  dack, mask_state, status_tc, status_req;
    logic [15:0] mem_addr;
    logic [1:0]  xfer_type;

    dma_xfer_seq uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit started = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [15:0] m_addr [4], m_cnt [4], m_baddr [4], m_bcnt [4];
    bit [5:0]  m_mode [4];
    bit [3:0]  m_mask, m_sreq, m_tc;
    bit        m_busy;
    int        m_chan, m_last;

    always @(posedge clk) begin
        bit [3:0] el;
        bit tcnow, endx, reqc;
        int c, op, pick, cc;
        if (rst) begin
            m_busy = 0; m_chan = 0; m_last = 3; m_mask = 4'hF; m_sreq = 0; m_tc = 0;
            for (int i = 0; i < 4; i++) begin
                m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0; m_mode[i] = 0;
            end
        end else begin
            el = (dreq | m_sreq) & ~m_mask;
            c = m_chan; tcnow = 0; endx = 0; reqc = 0; op = 0;
            if (m_busy) begin
                tcnow = (m_cnt[c] == 0);
                reqc  = dreq[c] | m_sreq[c];
                op    = int'(m_mode[c][5:4]);
                endx  = tcnow || eop_in;
                m_addr[c] = m_mode[c][3] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
                m_cnt[c]  = m_cnt[c] - 16'd1;
            end
            if (status_ack) m_tc = 0;
            if (mask_wr) m_mask = mask_data;
            if (sreq_wr) m_sreq[sreq_ch] = sreq_set;
            if (m_busy) begin
                if (endx) begin
                    if (m_mode[c][2]) begin
                        m_addr[c] = m_baddr[c]; m_cnt[c] = m_bcnt[c];
                    end else m_mask[c] = 1'b1;
                    if (tcnow) begin m_tc[c] = 1'b1; m_sreq[c] = 1'b0; end
                    m_busy = 0;
                end else if (op == 1) m_busy = 0;
                else if (op == 0 && !reqc) m_busy = 0;
            end else if (!ctl_disable && el != 0) begin
                pick = -1;
                for (int i = 0; i < 4; i++) begin
                    cc = ctl_rotate ? (m_last + 1 + i) % 4 : i;
                    if (pick < 0 && el[cc]) pick = cc;
                end
                m_busy = 1; m_chan = pick; m_last = pick;
            end
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: begin m_baddr[cfg_ch] = cfg_data; m_addr[cfg_ch] = cfg_data; end
                    2'd1: begin m_bcnt[cfg_ch] = cfg_data; m_cnt[cfg_ch] = cfg_data; end
                    2'd2: m_mode[cfg_ch] = cfg_data[7:2];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and transfer bookkeeping
    int  xcnt [4];
    int  b2b, nseq;
    int  seq [8];
    bit  prev_valid = 1'b0;

    always @(negedge clk) begin
        bit [3:0] exp_dack;
        if (started && !rst) begin
            exp_dack = m_busy ? 4'(1 << m_chan) : 4'h0;
            chk(xfer_valid == m_busy, "R3 xfer_valid", xfer_valid, m_busy);
            chk(dack == exp_dack, "R11 dack", dack, exp_dack);
            chk(tc_out == (m_busy && m_cnt[m_chan] == 0), "R5 tc_out", tc_out, m_busy && m_cnt[m_chan] == 0);
            if (m_busy) begin
                chk(mem_addr == m_addr[m_chan], "R4 mem_addr", mem_addr, m_addr[m_chan]);
                chk(xfer_type == m_mode[m_chan][1:0], "R3 xfer_type", xfer_type, m_mode[m_chan][1:0]);
            end
            chk(mask_state == m_mask, "R6 mask_state", mask_state, m_mask);
            chk(status_tc == m_tc, "R7 status_tc", status_tc, m_tc);
            chk(status_req == (dreq | m_sreq), "R12 status_req", status_req, dreq | m_sreq);
            if (xfer_valid) begin
                for (int i = 0; i < 4; i++) if (dack[i]) begin
                    xcnt[i]++;
                    if (nseq < 8) begin seq[nseq] = i; nseq++; end
                end
                if (prev_valid) b2b++;
            end
            prev_valid = xfer_valid;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask
    task automatic cfgw(input int ch, input int sel, input int data);
        cfg_wr = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = 16'(data);
        tick(); cfg_wr = 0;
    endtask
    task automatic maskw(input bit [3:0] v);
        mask_wr = 1; mask_data = v; tick(); mask_wr = 0;
    endtask
    task automatic clr();
        for (int i = 0; i < 4; i++) xcnt[i] = 0;
        b2b = 0; nseq = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        #1 rst = 0; started = 1;
        tick();
        // R1 reset state
        chk(mask_state == 4'hF, "R1 mask after reset", mask_state, 4'hF);
        chk(dack == 4'h0 && !xfer_valid, "R1 idle after reset", dack, 0);
        chk(status_tc == 4'h0, "R1 tc flags after reset", status_tc, 0);

        // single mode, write, count 2 on channel 1 with request held
        cfgw(1, 0, 'h1000); cfgw(1, 1, 2); cfgw(1, 2, 'h44);
        maskw(4'b1101); clr();
        dreq[1] = 1; repeat (12) tick(); dreq[1] = 0;
        chk(xcnt[1] == 3, "R5 count 2 moves 3 bytes", xcnt[1], 3);
        chk(b2b == 0, "R8 single mode gaps", b2b, 0);
        chk(mask_state[1] == 1, "R6 auto mask", mask_state[1], 1);
        chk(status_tc[1] == 1, "R7 tc flag set", status_tc[1], 1);

        // block mode, read, decrement, autoinitialize on channel 2
        cfgw(2, 0, 'h2005); cfgw(2, 1, 3); cfgw(2, 2, 'hB8);
        maskw(4'b1011); clr();
        dreq[2] = 1; tick(); dreq[2] = 0; repeat (10) tick();
        chk(xcnt[2] == 4, "R9 block run length", xcnt[2], 4);
        chk(b2b == 3, "R9 block back to back", b2b, 3);
        chk(mask_state[2] == 0, "R6 autoinit keeps mask", mask_state[2], 0);
        clr();
        dreq[2] = 1; tick(); dreq[2] = 0; repeat (10) tick();
        chk(xcnt[2] == 4, "R6 autoinit reload count", xcnt[2], 4);
        maskw(4'hF);

        // demand mode, verify, request held three cycles on channel 3
        cfgw(3, 0, 'h3000); cfgw(3, 1, 10); cfgw(3, 2, 'h00);
        maskw(4'b0111); clr();
        dreq[3] = 1; repeat (3) tick(); dreq[3] = 0; repeat (6) tick();
        chk(xcnt[3] == 3, "R10 demand stops with request", xcnt[3], 3);
        chk(status_tc[3] == 0, "R10 no tc in demand stop", status_tc[3], 0);
        maskw(4'hF);

        // external end of process during block run on channel 0
        cfgw(0, 0, 'h0400); cfgw(0, 1, 100); cfgw(0, 2, 'h88);
        maskw(4'b1110); clr();
        dreq[0] = 1; tick(); dreq[0] = 0; tick(); tick();
        eop_in = 1; tick(); eop_in = 0; repeat (5) tick();
        chk(xcnt[0] == 3, "R13 eop ends run", xcnt[0], 3);
        chk(mask_state[0] == 1, "R6 eop masks channel", mask_state[0], 1);
        chk(status_tc[0] == 0, "R13 eop leaves tc clear", status_tc[0], 0);

        // status acknowledge
        status_ack = 1; tick(); status_ack = 0;
        chk(status_tc == 4'h0, "R7 ack clears tc", status_tc, 0);

        // fixed priority between channels 0 and 3
        cfgw(0, 0, 'h0100); cfgw(0, 1, 1); cfgw(0, 2, 'h44);
        cfgw(3, 0, 'h0300); cfgw(3, 1, 1); cfgw(3, 2, 'h44);
        ctl_rotate = 0; maskw(4'b0110); clr();
        dreq = 4'b1001; repeat (12) tick(); dreq = 0;
        chk(seq[0] == 0 && seq[1] == 0, "R11 fixed order", seq[1], 0);
        chk(xcnt[3] == 2, "R11 low channel served after", xcnt[3], 2);

        // rotating priority
        cfgw(0, 1, 1); cfgw(3, 1, 1);
        ctl_rotate = 1; maskw(4'b0110); clr();
        dreq = 4'b1001; repeat (12) tick(); dreq = 0; ctl_rotate = 0;
        chk(seq[0] == 0, "R11 rotate first", seq[0], 0);
        chk(seq[1] == 3 && seq[2] == 0, "R11 rotate alternates", seq[1], 3);

        // software request on channel 1 with count 0
        cfgw(1, 1, 0); cfgw(1, 2, 'h44);
        maskw(4'b1101); clr();
        sreq_wr = 1; sreq_ch = 1; sreq_set = 1; tick(); sreq_wr = 0;
        repeat (6) tick();
        chk(xcnt[1] == 1, "R12 software request served", xcnt[1], 1);
        chk(status_req[1] == 0, "R12 request cleared at tc", status_req[1], 0);
        chk(status_tc[1] == 1, "R5 count 0 is one byte", status_tc[1], 1);

        // controller disable, then masked request
        cfgw(1, 1, 5);
        ctl_disable = 1; maskw(4'b1101); clr();
        dreq[1] = 1; repeat (6) tick();
        chk(xcnt[1] == 0, "R2 disabled controller", xcnt[1], 0);
        maskw(4'hF); ctl_disable = 0; repeat (6) tick();
        chk(xcnt[1] == 0, "R2 masked request ignored", xcnt[1], 0);
        dreq = 0; repeat (3) tick();

        summary();
        $finish;
    end
endmodule